// File: doc/BRIEF.md
# Configurable Subword Accumulating Adder

This block is a 36-bit accumulating adder. Its word is built from four 9-bit quarters, and it can be cut into independent subwords. Each instruction supplies a 5-bit index, which selects one 9-bit entry from a 32-entry configuration store. That entry sets three things: where the carry chain is broken, which quarters may be written, and how the quarters of the incoming memory operand are rearranged before the add.

On each executed instruction the accumulator takes the sum of itself and the rearranged operand. The sum is computed subword by subword. Each subword also reports its own signed overflow flag. Entries in the configuration store are written through a synchronous write port, so software can change the configuration on any instruction without stalling.

Top module: `subword_adder`

## Requirements
- R1: After reset the accumulator is zero, every overflow flag is zero and every configuration entry holds 9'h000.
- R2: A configuration write (`cfg_we`) lands at the clock edge. An instruction reads its entry combinationally through `cfg_idx`, so if a write and an instruction hit the same entry in the same cycle, the instruction uses the old contents.
- R3: Configuration fields are laid out as follows. Bits [1:0] select the split. Bits [5:2] are the activity flags for quarters 0..3, where quarter q is bits 9q+8..9q. Bits [8:6] select the permutation.
- R4: The split codes are: 0 gives one 36-bit word; 1 gives two 18-bit halves; 2 gives four 9-bit quarters; 3 gives a 27-bit piece in quarters 0..2 plus a 9-bit piece in quarter 3. No carry crosses a subword boundary.
- R5: Operand quarter j is taken from memory quarter ((j XOR perm[1:0]) + perm[2]) mod 4. For example, perm = 3'b010 swaps the two halves.
- R6: When an instruction runs, an inactive quarter keeps its accumulator value. Carry still passes through it inside its subword. A subword whose top quarter is inactive raises no overflow.
- R7: For each executed subword, signed two's-complement overflow is reported in the `ovf` bit of the subword's top quarter. All other `ovf` bits read zero.
- R8: When `exec` is low, the accumulator and `ovf` hold their values.
- R9: Each subword sum wraps modulo 2 to the power of the subword width.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Configuration write enable |
| cfg_waddr | input | 5 | Configuration entry to write |
| cfg_wdata | input | 9 | Configuration value to write |
| exec | input | 1 | Execute one add instruction |
| cfg_idx | input | 5 | Configuration entry used by the instruction |
| mem_op | input | 36 | Memory operand, before permutation |
| acc | output | 36 | Accumulator |
| ovf | output | 4 | Per-quarter overflow, valid at subword tops |

## Verification
Four properties are checked on every cycle: the accumulator and flags hold while idle, inactive quarters keep their contents, overflow flags appear only at active subword tops, and a configuration write is visible in the following cycle. The bench sweeps all 512 configuration values against an arithmetic model of the subword sums. It adds directed cases for the same-cycle write/read ordering and for overflow. Those are the only checks that show the exact carry boundaries, the permutation map and the overflow values.

// File: rtl/subword_adder.sv
module subword_adder #(
  parameter int QW = 9,
  parameter int IDXW = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [IDXW-1:0]   cfg_waddr,
  input  logic [8:0]        cfg_wdata,
  input  logic              exec,
  input  logic [IDXW-1:0]   cfg_idx,
  input  logic [4*QW-1:0]   mem_op,
  output logic [4*QW-1:0]   acc,
  output logic [3:0]        ovf
);
  localparam int W = 4 * QW;
  localparam int DEPTH = 1 << IDXW;

  logic [8:0] cfg_mem [DEPTH];
  logic [8:0] cfg;
  logic [1:0] split;
  logic [3:0] act;
  logic [2:0] perm;
  logic [2:0] brk;
  logic [3:0] top;
  logic [W-1:0] opnd, sum;
  logic [4:0] cy;
  logic [3:0] nov;

  assign cfg   = cfg_mem[cfg_idx];
  assign split = cfg[1:0];
  assign act   = cfg[5:2];
  assign perm  = cfg[8:6];
  assign top   = {1'b1, brk};
  assign cy[0] = 1'b0;

  always_comb begin
    case (split)
      2'd0:    brk = 3'b000;
      2'd1:    brk = 3'b010;
      2'd2:    brk = 3'b111;
      default: brk = 3'b100;
    endcase
  end

  for (genvar j = 0; j < 4; j++) begin : g_q
    logic [1:0] src;
    logic [QW:0] qs;
    assign src = (2'(j) ^ perm[1:0]) + {1'b0, perm[2]};
    assign opnd[j*QW +: QW] = mem_op[src*QW +: QW];
    assign qs = {1'b0, acc[j*QW +: QW]} + {1'b0, opnd[j*QW +: QW]} + (QW+1)'(cy[j]);
    assign sum[j*QW +: QW] = qs[QW-1:0];
    if (j < 3) begin : g_c
      assign cy[j+1] = qs[QW] & ~brk[j];
    end else begin : g_t
      assign cy[j+1] = qs[QW];
    end
    assign nov[j] = top[j] & act[j] &
                    (acc[j*QW+QW-1] == opnd[j*QW+QW-1]) &
                    (sum[j*QW+QW-1] != acc[j*QW+QW-1]);

    always_ff @(posedge clk) begin
      if (!rst_n) acc[j*QW +: QW] <= '0;
      else if (exec && act[j]) acc[j*QW +: QW] <= sum[j*QW +: QW];
    end

    a_r6_inactive_holds: assert property (@(posedge clk) disable iff (!rst_n)
      (exec && !act[j]) |=> acc[j*QW +: QW] == $past(acc[j*QW +: QW]));
  end

  always_ff @(posedge clk) begin
    if (!rst_n) ovf <= '0;
    else if (exec) ovf <= nov;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) cfg_mem[i] <= '0;
    end else if (cfg_we) begin
      cfg_mem[cfg_waddr] <= cfg_wdata;
    end
  end

  a_r8_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !exec |=> $stable(acc) && $stable(ovf));

  a_r7_ovf_at_tops: assert property (@(posedge clk) disable iff (!rst_n)
    exec |=> (ovf & ~$past(top & act)) == 4'b0);

  a_r2_cfg_write: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_we |=> cfg_mem[$past(cfg_waddr)] == $past(cfg_wdata));
endmodule

// File: tb/subword_adder_tb.sv
module subword_adder_tb_top;
  localparam int CLK_PERIOD = 10;

  logic clk = 0, rst_n = 0, cfg_we = 0, exec = 0;
  logic [4:0] cfg_waddr = 0, cfg_idx = 0;
  logic [8:0] cfg_wdata = 0;
  logic [35:0] mem_op = 0;
  logic [35:0] acc;
  logic [3:0] ovf;
  logic [35:0] m_acc;
  logic [3:0] m_ovf;
  int checks = 0, errors = 0;
  logic [35:0] lfsr = 36'h9_1234_5677;

  always #(CLK_PERIOD/2) clk = ~clk;

  subword_adder dut_i (.clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_waddr(cfg_waddr),
    .cfg_wdata(cfg_wdata), .exec(exec), .cfg_idx(cfg_idx), .mem_op(mem_op),
    .acc(acc), .ovf(ovf));

  function automatic logic [39:0] model(logic [35:0] a, logic [35:0] m, logic [8:0] c);
    logic [35:0] b, r;
    logic [3:0] o;
    r = a; o = 0;
    for (int j = 0; j < 4; j++) begin
      int s;
      s = (((j ^ int'(c[7:6])) + int'(c[8])) % 4);
      b[9*j +: 9] = m[9*s +: 9];
    end
    for (int q = 0; q < 4; q++) begin
      int st, n, w;
      longint unsigned mask, as, bs, ss;
      case (c[1:0])
        2'd0: begin st = 0; n = 4; end
        2'd1: begin st = (q < 2) ? 0 : 2; n = 2; end
        2'd2: begin st = q; n = 1; end
        default: begin st = (q < 3) ? 0 : 3; n = (q < 3) ? 3 : 1; end
      endcase
      w = 9 * n;
      mask = (64'd1 << w) - 1;
      as = (longint'(a) >> (9*st)) & mask;
      bs = (longint'(b) >> (9*st)) & mask;
      ss = (as + bs) & mask;
      if (c[2+q]) begin
        r[9*q +: 9] = 9'((ss >> (9*(q-st))) & 511);
        if (q == st + n - 1)
          o[q] = (as[w-1] == bs[w-1]) && (ss[w-1] != as[w-1]);
      end
    end
    return {o, r};
  endfunction

  task automatic check(string req, logic [35:0] ea, logic [3:0] eo);
    checks++;
    if (acc !== ea || ovf !== eo) begin
      errors++;
      $display("FAIL %s acc=%h ovf=%b expected acc=%h ovf=%b", req, acc, ovf, ea, eo);
    end
  endtask

  task automatic wr(logic [4:0] a, logic [8:0] d);
    @(negedge clk); cfg_we = 1; cfg_waddr = a; cfg_wdata = d;
    @(negedge clk); cfg_we = 0;
  endtask

  task automatic run(logic [4:0] idx, logic [35:0] m, logic [8:0] c, string req);
    logic [39:0] e;
    @(negedge clk); exec = 1; cfg_idx = idx; mem_op = m;
    @(negedge clk); exec = 0;
    e = model(m_acc, m, c);
    m_acc = e[35:0]; m_ovf = e[39:36];
    check(req, m_acc, m_ovf);
  endtask

  task automatic next_rand();
    lfsr = {lfsr[34:0], lfsr[35] ^ lfsr[24]};
    lfsr = lfsr * 36'd1103515245 + 36'd12345;
  endtask

  task automatic do_reset();
    @(negedge clk); rst_n = 0;
    @(negedge clk); @(negedge clk); rst_n = 1;
    m_acc = 0; m_ovf = 0;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    do_reset();
    check("R1 reset state", 36'h0, 4'h0);
    // R1: untouched entry is 0 -> all quarters inactive
    run(5'd7, 36'hF_FFFF_FFFF, 9'h000, "R1 R3 zero entry inactive");

    // R7: quarter split, all active, identity perm; 0FF+0FF overflows each quarter
    wr(5'd1, {3'b000, 4'b1111, 2'd2});
    run(5'd1, {4{9'h0FF}}, {3'b000, 4'b1111, 2'd2}, "R7 no overflow");
    run(5'd1, {4{9'h0FF}}, {3'b000, 4'b1111, 2'd2}, "R7 all quarters overflow");
    check("R7 directed", {4{9'h1FE}}, 4'hF);

    // R4 R9: full word carry through all quarters
    do_reset();
    wr(5'd2, {3'b000, 4'b1111, 2'd0});
    run(5'd2, {4{9'h1FF}}, {3'b000, 4'b1111, 2'd0}, "R4 full word");
    run(5'd2, 36'h0_0000_0001, {3'b000, 4'b1111, 2'd0}, "R9 full word wrap");
    check("R9 directed wrap", 36'h0, 4'h0);

    // R2: same-cycle write and read uses old entry
    do_reset();
    wr(5'd3, {3'b000, 4'b1111, 2'd2});
    @(negedge clk);
    exec = 1; cfg_idx = 5'd3; mem_op = {4{9'h005}};
    cfg_we = 1; cfg_waddr = 5'd3; cfg_wdata = 9'h000;
    @(negedge clk); exec = 0; cfg_we = 0;
    m_acc = {4{9'h005}};
    check("R2 old entry used", m_acc, 4'h0);
    run(5'd3, {4{9'h005}}, 9'h000, "R2 new entry after write");

    // R8: idle holds despite changing operand
    @(negedge clk); mem_op = 36'hA_5A5A_5A5A; cfg_idx = 5'd1;
    repeat (3) @(negedge clk);
    check("R8 idle hold", m_acc, m_ovf);

    // R5: halves swap example
    do_reset();
    wr(5'd4, {3'b010, 4'b1111, 2'd1});
    run(5'd4, {9'h001, 9'h002, 9'h003, 9'h004}, {3'b010, 4'b1111, 2'd1}, "R5 half swap");
    check("R5 directed", {9'h003, 9'h004, 9'h001, 9'h002}, 4'h0);

    // Sweep all 512 configuration values with pseudo-random operands
    do_reset();
    for (int c = 0; c < 512; c++) begin
      wr(5'(c % 32), 9'(c));
      for (int k = 0; k < 3; k++) begin
        next_rand();
        run(5'(c % 32), lfsr, 9'(c), "R3 R4 R5 R6 R7 R9 sweep");
      end
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule